// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block groups four hardware timers behind a small word-addressed register bus. Three of them are reloadable down-counters (two 16 bits wide, one 32 bits wide). Each has a reload register, a control byte, a readable current value and a write-only acknowledge location, and each raises its own interrupt line when it passes through zero. The fourth is a 40-bit free-running up-counter. It runs on a separate, faster tick, is switched on by a bit in its upper readback word and never interrupts.

Tick rates are not generated here. Three single-cycle clock enables arrive from outside: a slow tick (nominally about 508 kHz), an alternative tick that a channel may select instead, and a fast tick (nominally 983.04 kHz) for the wide counter. A periodic interrupt of N slow ticks is set up by writing N-1 to the reload register, then the control value 0x48, then 0xC8.

Each reloadable channel holds two small state machines. The run machine has the states CH_IDLE and CH_COUNT: a control write with bit 7 set moves it from CH_IDLE to CH_COUNT, and one with bit 7 clear moves it back. The interrupt machine has the states IRQ_QUIET and IRQ_PENDING: an underflow moves it from IRQ_QUIET to IRQ_PENDING, and an acknowledge write without a coincident underflow moves it back. The wide counter has FR_HALT and FR_RUN, chosen on every write to its upper word by bit 8 of the written data.

Top module: `tmr_bank`

## Requirements
- R1: After reset every counter, reload register and control byte reads 0, all interrupt lines are low and the wide counter is halted at 0.
- R2: Word address bits [3:2] select channel c (0..2) and bits [1:0] its register: 0 reload (read/write), 1 current value (read-only), 2 control (read/write), 3 acknowledge (write-only, reads 0). Address 12 reads the wide counter's low word, address 13 its upper word, and every other address reads 0. A reload write also puts the written value into the counter at once.
- R3: Control bit 7 runs the channel, bit 6 selects periodic mode and bit 3 selects the slow tick (1) or the alternative tick (0). The control readback shows those three bits and zeros elsewhere. A channel that is not running ignores every tick.
- R4: A running channel decrements once per selected tick. A tick at value 0 is an underflow; in periodic mode the counter then takes the reload value, so reload N gives an N+1 tick period.
- R5: Without periodic mode an underflow wraps the counter to the all-ones value of its width.
- R6: An underflow raises the channel's interrupt line one cycle later, and the line stays high until a write of any data to the channel's acknowledge address.
- R7: An acknowledge write in the same cycle as an underflow leaves the interrupt line high.
- R8: Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide; written data is truncated to the channel width and read back zero-extended.
- R9: Writing the upper word with bit 8 set starts the wide counter, and writing it with bit 8 clear stops it. While running it increments once per fast tick. Writes never change its count, and it drives no interrupt.
- R10: The wide counter's low word returns count bits [31:0]. The upper word returns count bits [39:32] in bits 7:0 and the run flag in bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tick_slow | input | 1 | Slow tick enable |
| tick_alt | input | 1 | Alternative tick enable |
| tick_fast | input | 1 | Fast tick enable for the wide counter |
| irq | output | 3 | Per-channel underflow interrupt |

## Verification
The bench builds the unit with its default parameters: two 16-bit channels, one 32-bit channel and a 40-bit wide counter split at bit 32. These widths bring the 16-bit all-ones wrap, truncation of a 17-bit write and the 32-bit all-ones reload within reach in a few ticks. The carry into the wide counter's upper byte would take 2^32 fast ticks, so only its readback position and the run flag are checked there. The ticks are driven directly, so the bench can place an acknowledge write in the same cycle as an underflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {CH_IDLE, CH_COUNT} ch_state_e;
    typedef enum logic {IRQ_QUIET, IRQ_PENDING} irq_state_e;
    typedef enum logic {FR_HALT, FR_RUN} fr_state_e;

    localparam int CTRL_RUN_BIT  = 7;
    localparam int CTRL_PER_BIT  = 6;
    localparam int CTRL_SLOW_BIT = 3;
    localparam int FREE_RUN_BIT  = 8;

    localparam logic [1:0] REG_RELOAD = 2'd0;
    localparam logic [1:0] REG_VALUE  = 2'd1;
    localparam logic [1:0] REG_CTRL   = 2'd2;
    localparam logic [1:0] REG_ACK    = 2'd3;

endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int W      = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_reload,
    input  logic              wr_ctrl,
    input  logic              wr_ack,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_slow,
    input  logic              tick_alt,
    output logic [W-1:0]      count,
    output logic [W-1:0]      reload,
    output logic [7:0]        ctrl_rd,
    output logic              irq
);

    ch_state_e  run_q, run_d;
    irq_state_e irq_q, irq_d;
    logic       periodic_q;
    logic       slow_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] reload_q;
    logic       tick_sel;
    logic       step;
    logic       underflow;

    assign tick_sel  = slow_q ? tick_slow : tick_alt;
    assign step      = (run_q == CH_COUNT) && tick_sel && !wr_reload;
    assign underflow = step && (cnt_q == '0);

    // run state machine
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            CH_IDLE:  if (wr_ctrl && wdata[CTRL_RUN_BIT])  run_d = CH_COUNT;
            CH_COUNT: if (wr_ctrl && !wdata[CTRL_RUN_BIT]) run_d = CH_IDLE;
            default:  run_d = CH_IDLE;
        endcase
    end

    // interrupt state machine
    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_QUIET:   if (underflow)            irq_d = IRQ_PENDING;
            IRQ_PENDING: if (wr_ack && !underflow) irq_d = IRQ_QUIET;
            default:     irq_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= CH_IDLE;
            irq_q <= IRQ_QUIET;
        end else begin
            run_q <= run_d;
            irq_q <= irq_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periodic_q <= 1'b0;
            slow_q     <= 1'b0;
            reload_q   <= '0;
            cnt_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                periodic_q <= wdata[CTRL_PER_BIT];
                slow_q     <= wdata[CTRL_SLOW_BIT];
            end
            if (wr_reload) begin
                reload_q <= wdata[W-1:0];
                cnt_q    <= wdata[W-1:0];
            end else if (step) begin
                if (cnt_q == '0) cnt_q <= periodic_q ? reload_q : '1;
                else             cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[CTRL_RUN_BIT]  = (run_q == CH_COUNT);
        ctrl_rd[CTRL_PER_BIT]  = periodic_q;
        ctrl_rd[CTRL_SLOW_BIT] = slow_q;
        count                  = cnt_q;
        reload                 = reload_q;
        irq                    = (irq_q == IRQ_PENDING);
    end

endmodule

// File: rtl/tmr_wide.sv
module tmr_wide
    import tmr_pkg::*;
#(
    parameter int W      = 40,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_fast,
    output logic [W-1:0]      count,
    output logic              running
);

    fr_state_e st_q, st_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_HALT: if (wr_hi && wdata[FREE_RUN_BIT])  st_d = FR_RUN;
            FR_RUN:  if (wr_hi && !wdata[FREE_RUN_BIT]) st_d = FR_HALT;
            default: st_d = FR_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FR_HALT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (st_q == FR_RUN && tick_fast) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        count   = cnt_q;
        running = (st_q == FR_RUN);
    end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int BROAD_W  = 32,
    parameter int FREE_W   = 40,
    parameter int NCH      = 3,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_slow,
    input  logic              tick_alt,
    input  logic              tick_fast,
    output logic [NCH-1:0]    irq
);

    localparam int DATA_W = 32;
    localparam int LOW_W  = 32;
    localparam int HI_W   = FREE_W - LOW_W;
    localparam logic [ADDR_W-1:0] FREE_LO_ADDR = ADDR_W'(4 * NCH);
    localparam logic [ADDR_W-1:0] FREE_HI_ADDR = ADDR_W'(4 * NCH + 1);

    logic [ADDR_W-3:0] ch_idx;
    logic [1:0]        reg_idx;
    logic [BROAD_W-1:0] count_ext  [NCH];
    logic [BROAD_W-1:0] reload_ext [NCH];
    logic [7:0]         ctrl_rd    [NCH];
    logic [FREE_W-1:0]  free_count;
    logic               free_running;
    logic               wr_free_hi;

    assign ch_idx     = bus_addr[ADDR_W-1:2];
    assign reg_idx    = bus_addr[1:0];
    assign wr_free_hi = bus_wr && (bus_addr == FREE_HI_ADDR);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int CW = (g == NCH - 1) ? BROAD_W : NARROW_W;
        logic          hit;
        logic [CW-1:0] cnt_w;
        logic [CW-1:0] rld_w;

        assign hit = bus_wr && (ch_idx == (ADDR_W-2)'(g));

        tmr_chan #(.W(CW), .DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_reload (hit && reg_idx == REG_RELOAD),
            .wr_ctrl   (hit && reg_idx == REG_CTRL),
            .wr_ack    (hit && reg_idx == REG_ACK),
            .wdata     (bus_wdata),
            .tick_slow (tick_slow),
            .tick_alt  (tick_alt),
            .count     (cnt_w),
            .reload    (rld_w),
            .ctrl_rd   (ctrl_rd[g]),
            .irq       (irq[g])
        );

        assign count_ext[g]  = BROAD_W'(cnt_w);
        assign reload_ext[g] = BROAD_W'(rld_w);
    end

    tmr_wide #(.W(FREE_W), .DATA_W(DATA_W)) u_wide (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hi     (wr_free_hi),
        .wdata     (bus_wdata),
        .tick_fast (tick_fast),
        .count     (free_count),
        .running   (free_running)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_idx == (ADDR_W-2)'(i)) begin
                unique case (reg_idx)
                    REG_RELOAD: bus_rdata = DATA_W'(reload_ext[i]);
                    REG_VALUE:  bus_rdata = DATA_W'(count_ext[i]);
                    REG_CTRL:   bus_rdata = DATA_W'(ctrl_rd[i]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
        if (bus_addr == FREE_LO_ADDR) begin
            bus_rdata = free_count[LOW_W-1:0];
        end else if (bus_addr == FREE_HI_ADDR) begin
            bus_rdata               = '0;
            bus_rdata[HI_W-1:0]     = free_count[FREE_W-1:LOW_W];
            bus_rdata[FREE_RUN_BIT] = free_running;
        end
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NCH    = 3,
    parameter int ADDR_W = 4,
    parameter int FREE_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tick_slow,
    input logic              tick_alt,
    input logic              tick_fast,
    input logic [NCH-1:0]    irq,
    input logic [FREE_W-1:0] free_cnt,
    input logic              free_run
);

    localparam logic [ADDR_W-1:0] ACK0 = ADDR_W'(3);

    // R6: a pending line holds until channel 0 is acknowledged
    a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] && !(bus_wr && bus_addr == ACK0)) |=> irq[0]);

    // R6: an acknowledge with no tick around drops the line
    a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ACK0 && !tick_slow && !tick_alt) |=> !irq[0]);

    // R4: an interrupt only rises after a tick
    a_r4_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> $past(tick_slow || tick_alt));

    // R9: no fast tick, no change of the wide count
    a_r9_free_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_fast |=> $stable(free_cnt));

    // R9: a fast tick while running adds one
    a_r9_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_fast && free_run) |=> (free_cnt == $past(free_cnt) + 1'b1));

endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .FREE_W(FREE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .tick_slow (tick_slow),
    .tick_alt  (tick_alt),
    .tick_fast (tick_fast),
    .irq       (irq),
    .free_cnt  (free_count),
    .free_run  (free_running)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_slow = 1'b0;
    logic        tick_alt = 1'b0;
    logic        tick_fast = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_slow (tick_slow),
        .tick_alt  (tick_alt),
        .tick_fast (tick_fast),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_with_slow(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_slow = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_slow = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // kind: 0 slow, 1 alt, 2 fast
    task automatic ticks(input int kind, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (kind == 0) tick_slow = 1'b1;
            else if (kind == 1) tick_alt = 1'b1;
            else tick_fast = 1'b1;
            @(negedge clk);
            tick_slow = 1'b0; tick_alt = 1'b0; tick_fast = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d);  chk("R1 reload0", d, 0);
        rd(4'd1, d);  chk("R1 value0", d, 0);
        rd(4'd2, d);  chk("R1 ctrl0", d, 0);
        rd(4'd9, d);  chk("R1 value2", d, 0);
        rd(4'd12, d); chk("R1 free lo", d, 0);
        rd(4'd13, d); chk("R1 free hi", d, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        wr(4'd0, 32'd3);
        rd(4'd1, d); chk("R2 value after reload write", d, 3);
        rd(4'd0, d); chk("R2 reload readback", d, 3);
        wr(4'd2, 32'h48);
        rd(4'd2, d); chk("R3 ctrl readback 48", d, 32'h48);
        ticks(0, 2);
        rd(4'd1, d); chk("R3 stopped channel ignores ticks", d, 3);
        wr(4'd2, 32'hC8);
        rd(4'd2, d); chk("R3 ctrl readback C8", d, 32'hC8);
        ticks(0, 3);
        rd(4'd1, d); chk("R4 value after 3 ticks", d, 0);
        chk("R6 no irq before underflow", 32'(irq[0]), 0);
        ticks(0, 1);
        rd(4'd1, d); chk("R4 reload on underflow", d, 3);
        chk("R6 irq after underflow", 32'(irq[0]), 1);
        ticks(0, 2);
        rd(4'd1, d); chk("R4 decrement after reload", d, 1);
        chk("R6 irq held", 32'(irq[0]), 1);
        wr(4'd3, 32'hDEAD);
        chk("R6 irq cleared by ack", 32'(irq[0]), 0);
    endtask

    task automatic t_coincide();
        logic [31:0] d;
        ticks(0, 1);
        rd(4'd1, d); chk("R7 value before underflow", d, 0);
        wr_with_slow(4'd3, 32'h0);
        chk("R7 ack with underflow keeps irq", 32'(irq[0]), 1);
        rd(4'd1, d); chk("R7 reload on coincident underflow", d, 3);
        wr(4'd3, 32'h0);
        chk("R7 later ack clears", 32'(irq[0]), 0);
        wr(4'd2, 32'h48);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(4'd4, 32'd0);
        wr(4'd6, 32'h88);
        ticks(0, 1);
        rd(4'd5, d); chk("R5 wrap to all ones 16-bit", d, 32'h0000_FFFF);
        chk("R6 irq1 on wrap", 32'(irq[1]), 1);
        ticks(0, 1);
        rd(4'd5, d); chk("R5 decrement after wrap", d, 32'h0000_FFFE);
        wr(4'd7, 32'h0);
    endtask

    task automatic t_alt();
        logic [31:0] d;
        wr(4'd4, 32'd2);
        wr(4'd6, 32'hC0);
        ticks(1, 2);
        rd(4'd5, d); chk("R3 alt tick counts", d, 0);
        ticks(0, 2);
        rd(4'd5, d); chk("R3 slow tick ignored on alt", d, 0);
        chk("R3 no irq from ignored ticks", 32'(irq[1]), 0);
        ticks(1, 1);
        rd(4'd5, d); chk("R4 alt reload", d, 2);
        chk("R6 irq1 on alt underflow", 32'(irq[1]), 1);
        wr(4'd6, 32'h00);
        wr(4'd7, 32'h0);
    endtask

    task automatic t_width();
        logic [31:0] d;
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd9, d); chk("R8 32-bit channel full width", d, 32'hFFFF_FFFF);
        wr(4'd10, 32'h88);
        ticks(0, 1);
        rd(4'd9, d); chk("R8 32-bit decrement", d, 32'hFFFF_FFFE);
        wr(4'd10, 32'h08);
        wr(4'd0, 32'h0001_2345);
        rd(4'd1, d); chk("R8 16-bit truncation", d, 32'h0000_2345);
        rd(4'd14, d); chk("R2 unmapped reads zero", d, 0);
        rd(4'd3, d); chk("R2 ack reads zero", d, 0);
    endtask

    task automatic t_free();
        logic [31:0] d;
        ticks(2, 3);
        rd(4'd12, d); chk("R9 halted counter ignores fast tick", d, 0);
        wr(4'd13, 32'h100);
        rd(4'd13, d); chk("R10 hi shows run flag", d, 32'h100);
        ticks(2, 5);
        rd(4'd12, d); chk("R9 counts fast ticks", d, 5);
        ticks(0, 3);
        rd(4'd12, d); chk("R9 slow ticks ignored", d, 5);
        chk("R9 no interrupt from wide counter", 32'(irq), 0);
        wr(4'd13, 32'h0FF);
        rd(4'd13, d); chk("R10 hi after stop write", d, 0);
        rd(4'd12, d); chk("R9 write leaves count", d, 5);
        ticks(2, 2);
        rd(4'd12, d); chk("R9 stopped counter holds", d, 5);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_coincide();
        t_wrap();
        t_alt();
        t_width();
        t_free();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule